// File: doc/BRIEF.md
# Sticky Interrupt Aggregator

This block gathers a set of error flags and a set of status levels into two interrupt lines, one for errors and one for events. Error sources arrive as single-cycle pulses that set bits in a sticky error-status register. Event sources arrive as live levels. A mask register for each group picks which sources may raise its line. A pending register holds one bit per line. Software clears a pending bit by writing a one to it, and clears error-status bits the same way. A test register forces either line for one cycle.

Each line is a two-state machine. In `LN_CLEAR` the bit is not pending. The transition *raise* (`LN_CLEAR` → `LN_PENDING`) happens at a clock edge when the line's enable bit is set and the line has a cause: its test bit is written in that cycle, or a masked raising source is present. In `LN_PENDING` the bit is held. Further causes are not evaluated in that state. The transition *clear* (`LN_PENDING` → `LN_CLEAR`) happens on a write of one to the line's pending bit. Each interrupt output is the pending bit gated by the line's enable bit.

Software reaches the block through a single-cycle write port (`wr_en`, `wr_sel`, `wr_data`) and a combinational read port (`rd_sel`, `rd_data`). The register selects are:
- 0: pending register. Bit 0 is the error line and bit 1 is the event line. Writing a one clears the bit.
- 1: line enable, same bit layout.
- 2: test, same bit layout. It is write-only and reads as zero.
- 3: error mask.
- 4: error status. Writing a one clears the bit.
- 5: event mask.
- 6 and 7: unused. They read as zero.

Top module: `sticky_irq_agg`

## Requirements
- R1: After reset the pending, enable and event-mask registers read 0, the error mask reads 0x1F, the error status reads 0, and both interrupt outputs are low.
- R2: An error pulse on bit k sets error-status bit k at the next edge, and the bit holds until a write to select 4 with data bit k set. When a pulse and a clear of the same bit fall in the same cycle, the pulse wins. The bits are: 0 command busy, 1 overflow, 2 underflow, 3 invalid command, 4 invalid chip select, 5 invalid access.
- R3: The error line raises when it is enabled (enable bit 0), not pending, and error-status bit 0, 3 or 4 is set together with its error-mask bit. Overflow, underflow and invalid access (bits 1, 2 and 5) never raise it.
- R4: The event line raises when it is enabled (enable bit 1), not pending, and event level bit 0 (RX full), 1 (TX empty) or 4 (ready) is high together with its event-mask bit. Bits 2 (RX watermark), 3 (TX watermark) and 5 (idle) never raise it.
- R5: A write to select 2 with bit 0 or bit 1 set raises the matching enabled, non-pending line at that edge. The write is not stored: select 2 reads 0, and the line does not raise again after it is cleared.
- R6: A line whose enable bit is 0 does not become pending, even when a cause is present. Once the line is enabled, a cause that is still present raises it one edge after the enable write.
- R7: A pending bit stays set until software writes a one to it at select 0. Writing a zero to that bit has no effect.
- R8: Each interrupt output equals its pending bit ANDed with its enable bit. Clearing the enable bit drops the output while the pending bit stays set.
- R9: If a level cause persists through a clear, the pending bit reads 0 for exactly one cycle and is then set again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| wr_sel | input | 3 | Register select for the write |
| wr_data | input | DW (6) | Write data |
| rd_sel | input | 3 | Register select for the read |
| rd_data | output | DW (6) | Read data, combinational |
| err_pulse | input | ERR_W (6) | Error set pulses, one bit per error kind |
| evt_level | input | EVT_W (6) | Event status levels |
| irq_err | output | 1 | Error interrupt |
| irq_evt | output | 1 | Event interrupt |

## Verification
The bench builds the block with its default parameters: six error kinds, six event levels, an error-mask reset of 0x1F, and raising masks 0x19 for errors and 0x13 for events. With these values a 6-bit write reaches every mask bit and every status bit. This lets random writes hit the non-raising sources, the clear and set collisions, and writes to the unused selects, alongside the raising ones. Directed sequences cover re-raise after a clear, gating by the enable bit, and a test write that is not stored.

// File: rtl/sticky_irq_pkg.sv
package sticky_irq_pkg;

    localparam int SEL_W = 3;

    typedef enum logic [SEL_W-1:0] {
        SEL_PEND  = 3'd0,
        SEL_LNEN  = 3'd1,
        SEL_FORCE = 3'd2,
        SEL_EMASK = 3'd3,
        SEL_ESTAT = 3'd4,
        SEL_VMASK = 3'd5
    } reg_sel_e;

    typedef enum logic {
        LN_CLEAR   = 1'b0,
        LN_PENDING = 1'b1
    } line_state_e;

    localparam int LINE_ERR = 0;
    localparam int LINE_EVT = 1;
    localparam int N_LINES  = 2;

endpackage

// File: rtl/sirq_err_latch.sv
module sirq_err_latch #(
    parameter int W = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_i,
    input  logic [W-1:0] clr_i,
    output logic [W-1:0] stat_o
);
    logic [W-1:0] stat_q;

    // a set in the same cycle as a clear wins
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stat_q <= '0;
        else        stat_q <= (stat_q & ~clr_i) | set_i;
    end

    assign stat_o = stat_q;
endmodule

// File: rtl/sirq_cause.sv
module sirq_cause #(
    parameter int           W     = 6,
    parameter logic [W-1:0] RAISE = '1
) (
    input  logic         force_i,
    input  logic [W-1:0] src_i,
    input  logic [W-1:0] mask_i,
    output logic         cause_o
);
    always_comb begin
        cause_o = force_i | (|(src_i & mask_i & RAISE));
    end
endmodule

// File: rtl/sirq_line_fsm.sv
module sirq_line_fsm
    import sticky_irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    input  logic cause_i,
    input  logic clr_i,
    output logic pending_o,
    output logic irq_o
);
    line_state_e cur_q, nxt;

    always_comb begin
        nxt = cur_q;
        unique case (cur_q)
            LN_CLEAR:   if (en_i && cause_i) nxt = LN_PENDING;
            LN_PENDING: if (clr_i)           nxt = LN_CLEAR;
            default:                         nxt = LN_CLEAR;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= LN_CLEAR;
        else        cur_q <= nxt;
    end

    always_comb begin
        pending_o = (cur_q == LN_PENDING);
        irq_o     = pending_o & en_i;
    end
endmodule

// File: rtl/sticky_irq_agg.sv
module sticky_irq_agg
    import sticky_irq_pkg::*;
#(
    parameter int               ERR_W     = 6,
    parameter int               EVT_W     = 6,
    parameter logic [ERR_W-1:0] EMASK_RST = 6'h1F,
    parameter logic [ERR_W-1:0] ERR_RAISE = 6'b011001,
    parameter logic [EVT_W-1:0] EVT_RAISE = 6'b010011,
    localparam int              DW        = (ERR_W > EVT_W) ? ERR_W : EVT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [SEL_W-1:0] wr_sel,
    input  logic [DW-1:0]    wr_data,
    input  logic [SEL_W-1:0] rd_sel,
    output logic [DW-1:0]    rd_data,
    input  logic [ERR_W-1:0] err_pulse,
    input  logic [EVT_W-1:0] evt_level,
    output logic             irq_err,
    output logic             irq_evt
);
    logic [N_LINES-1:0] ien;
    logic [N_LINES-1:0] istate;
    logic [N_LINES-1:0] line_irq;
    logic [N_LINES-1:0] force_now;
    logic [N_LINES-1:0] pend_clr;
    logic [N_LINES-1:0] cause;
    logic [ERR_W-1:0]   emask;
    logic [EVT_W-1:0]   vmask;
    logic [ERR_W-1:0]   estat;
    logic [ERR_W-1:0]   estat_clr;

    always_comb begin
        force_now = '0;
        pend_clr  = '0;
        estat_clr = '0;
        if (wr_en && wr_sel == SEL_FORCE) force_now = wr_data[N_LINES-1:0];
        if (wr_en && wr_sel == SEL_PEND)  pend_clr  = wr_data[N_LINES-1:0];
        if (wr_en && wr_sel == SEL_ESTAT) estat_clr = wr_data[ERR_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ien   <= '0;
            emask <= EMASK_RST;
            vmask <= '0;
        end else if (wr_en) begin
            if (wr_sel == SEL_LNEN)  ien   <= wr_data[N_LINES-1:0];
            if (wr_sel == SEL_EMASK) emask <= wr_data[ERR_W-1:0];
            if (wr_sel == SEL_VMASK) vmask <= wr_data[EVT_W-1:0];
        end
    end

    sirq_err_latch #(.W(ERR_W)) u_estat (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (err_pulse),
        .clr_i  (estat_clr),
        .stat_o (estat)
    );

    sirq_cause #(.W(ERR_W), .RAISE(ERR_RAISE)) u_err_cause (
        .force_i (force_now[LINE_ERR]),
        .src_i   (estat),
        .mask_i  (emask),
        .cause_o (cause[LINE_ERR])
    );

    sirq_cause #(.W(EVT_W), .RAISE(EVT_RAISE)) u_evt_cause (
        .force_i (force_now[LINE_EVT]),
        .src_i   (evt_level),
        .mask_i  (vmask),
        .cause_o (cause[LINE_EVT])
    );

    for (genvar g = 0; g < N_LINES; g++) begin : g_line
        sirq_line_fsm u_fsm (
            .clk       (clk),
            .rst_n     (rst_n),
            .en_i      (ien[g]),
            .cause_i   (cause[g]),
            .clr_i     (pend_clr[g]),
            .pending_o (istate[g]),
            .irq_o     (line_irq[g])
        );
    end

    assign irq_err = line_irq[LINE_ERR];
    assign irq_evt = line_irq[LINE_EVT];

    always_comb begin
        rd_data = '0;
        case (rd_sel)
            SEL_PEND:  rd_data = DW'(istate);
            SEL_LNEN:  rd_data = DW'(ien);
            SEL_EMASK: rd_data = DW'(emask);
            SEL_ESTAT: rd_data = DW'(estat);
            SEL_VMASK: rd_data = DW'(vmask);
            default:   rd_data = '0;
        endcase
    end
endmodule

// File: rtl/sticky_irq_agg_chk.sv
module sticky_irq_agg_chk
    import sticky_irq_pkg::*;
#(
    parameter int ERR_W = 6,
    parameter int DW    = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic [SEL_W-1:0] wr_sel,
    input logic [DW-1:0]    wr_data,
    input logic [ERR_W-1:0] err_pulse,
    input logic [1:0]       istate,
    input logic [1:0]       ien,
    input logic [ERR_W-1:0] estat,
    input logic             irq_err,
    input logic             irq_evt
);
    AST_ERR_OUT_NEEDS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
        irq_err |-> istate[0]); // R8
    AST_EVT_OUT_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        irq_evt |-> ien[1]); // R8
    AST_PEND_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (istate[0] && !(wr_en && wr_sel == SEL_PEND && wr_data[0])) |=> istate[0]); // R7
    AST_RAISE_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        (!ien[1] && !istate[1]) |=> !istate[1]); // R6
    AST_ESTAT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (err_pulse != '0) |=> ((estat & $past(err_pulse)) == $past(err_pulse))); // R2
    AST_ESTAT_W1C: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == SEL_ESTAT)
        |=> ((estat & $past(wr_data[ERR_W-1:0] & ~err_pulse)) == '0)); // R2
endmodule

bind sticky_irq_agg sticky_irq_agg_chk #(.ERR_W(ERR_W), .DW(DW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_sel    (wr_sel),
    .wr_data   (wr_data),
    .err_pulse (err_pulse),
    .istate    (istate),
    .ien       (ien),
    .estat     (estat),
    .irq_err   (irq_err),
    .irq_evt   (irq_evt)
);

// File: tb/sticky_irq_agg_bench.sv
module sticky_irq_agg_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_sel = '0;
    logic [5:0] wr_data = '0;
    logic [2:0] rd_sel = '0;
    logic [5:0] rd_data;
    logic [5:0] err_pulse = '0;
    logic [5:0] evt_level = '0;
    logic       irq_err, irq_evt;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // reference model state
    logic [1:0] m_pend = '0, m_en = '0;
    logic [5:0] m_emask = 6'h1F, m_estat = '0, m_vmask = '0;

    always #5 clk = ~clk;

    sticky_irq_agg u_sticky_irq_agg (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .rd_sel(rd_sel), .rd_data(rd_data), .err_pulse(err_pulse), .evt_level(evt_level),
        .irq_err(irq_err), .irq_evt(irq_evt)
    );

    task automatic check(input string tag, input logic [5:0] act, input logic [5:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [5:0] model_read(input logic [2:0] s);
        case (s)
            3'd0: return {4'b0, m_pend};
            3'd1: return {4'b0, m_en};
            3'd3: return m_emask;
            3'd4: return m_estat;
            3'd5: return m_vmask;
            default: return 6'h00;
        endcase
    endfunction

    function automatic string sel_tag(input logic [2:0] s);
        case (s)
            3'd0: return "R7 pending";
            3'd4: return "R2 error status";
            3'd2: return "R5 test reads zero";
            default: return "R1 register readback";
        endcase
    endfunction

    // model of one clock edge, built from the requirements
    task automatic model_edge();
        logic [1:0] frc, clr;
        logic ecause, vcause;
        logic [5:0] eclr;
        frc  = (wr_en && wr_sel == 3'd2) ? wr_data[1:0] : 2'b00;
        clr  = (wr_en && wr_sel == 3'd0) ? wr_data[1:0] : 2'b00;
        eclr = (wr_en && wr_sel == 3'd4) ? wr_data : 6'h00;
        ecause = frc[0] | (|(m_emask & m_estat & 6'b011001));
        vcause = frc[1] | (m_vmask[0] & evt_level[0]) | (m_vmask[1] & evt_level[1])
                        | (m_vmask[4] & evt_level[4]);
        m_pend[0] = m_pend[0] ? !clr[0] : (m_en[0] & ecause);
        m_pend[1] = m_pend[1] ? !clr[1] : (m_en[1] & vcause);
        m_estat = (m_estat & ~eclr) | err_pulse;
        if (wr_en && wr_sel == 3'd1) m_en = wr_data[1:0];
        if (wr_en && wr_sel == 3'd3) m_emask = wr_data;
        if (wr_en && wr_sel == 3'd5) m_vmask = wr_data;
    endtask

    // drive one cycle, advance the model, then compare away from the edge
    task automatic cycle(input logic we, input logic [2:0] s, input logic [5:0] d,
                         input logic [5:0] ep, input logic [2:0] rs);
        wr_en = we; wr_sel = s; wr_data = d; err_pulse = ep;
        @(posedge clk);
        model_edge();
        #2;
        wr_en = 1'b0; err_pulse = '0;
        rd_sel = rs;
        #1;
        check("R8 irq_err", {5'b0, irq_err}, {5'b0, m_pend[0] & m_en[0]});
        check("R8 irq_evt", {5'b0, irq_evt}, {5'b0, m_pend[1] & m_en[1]});
        check(sel_tag(rs), rd_data, model_read(rs));
    endtask

    task automatic rdchk(input string tag, input logic [2:0] s, input logic [5:0] exp);
        rd_sel = s; #1;
        check(tag, rd_data, exp);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin : stim
        int unsigned seed;
        seed = 32'd2024;
        void'($urandom(seed));
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        #1;
        // R1 reset state
        rdchk("R1 pending", 3'd0, 6'h00);
        rdchk("R1 enable", 3'd1, 6'h00);
        rdchk("R1 error mask", 3'd3, 6'h1F);
        rdchk("R1 error status", 3'd4, 6'h00);
        rdchk("R1 event mask", 3'd5, 6'h00);
        check("R1 irq_err low", {5'b0, irq_err}, 6'h00);
        check("R1 irq_evt low", {5'b0, irq_evt}, 6'h00);

        // R3: overflow does not raise, command busy does
        cycle(1, 3'd1, 6'h01, 6'h00, 3'd1);
        cycle(0, 3'd0, 6'h00, 6'h02, 3'd4);
        cycle(0, 3'd0, 6'h00, 6'h00, 3'd4);
        check("R3 overflow no raise", {5'b0, irq_err}, 6'h00);
        check("R2 overflow latched", rd_data, 6'h02);
        cycle(0, 3'd0, 6'h00, 6'h01, 3'd0);
        check("R3 not yet raised", {5'b0, irq_err}, 6'h00);
        cycle(0, 3'd0, 6'h00, 6'h00, 3'd0);
        check("R3 command busy raises", {5'b0, irq_err}, 6'h01);
        // R7: clearing causes and writing zero leave pending set
        cycle(1, 3'd4, 6'h03, 6'h00, 3'd4);
        check("R2 status cleared", rd_data, 6'h00);
        cycle(1, 3'd0, 6'h02, 6'h00, 3'd0);
        check("R7 zero write no effect", {5'b0, irq_err}, 6'h01);
        cycle(1, 3'd0, 6'h01, 6'h00, 3'd0);
        check("R7 cleared", {5'b0, irq_err}, 6'h00);
        // R5: test write raises, is not stored
        cycle(1, 3'd2, 6'h01, 6'h00, 3'd2);
        check("R5 test raises", {5'b0, irq_err}, 6'h01);
        check("R5 test reads zero", rd_data, 6'h00);
        cycle(1, 3'd0, 6'h01, 6'h00, 3'd0);
        cycle(0, 3'd0, 6'h00, 6'h00, 3'd0);
        check("R5 not stored", {5'b0, irq_err}, 6'h00);

        // R4: watermarks and idle do not raise, TX empty does
        evt_level = 6'b101100;
        cycle(1, 3'd5, 6'h3F, 6'h00, 3'd5);
        cycle(1, 3'd1, 6'h03, 6'h00, 3'd1);
        cycle(0, 3'd0, 6'h00, 6'h00, 3'd0);
        check("R4 non-raising levels", {5'b0, irq_evt}, 6'h00);
        evt_level = 6'b000010;
        cycle(0, 3'd0, 6'h00, 6'h00, 3'd0);
        check("R4 TX empty raises", {5'b0, irq_evt}, 6'h01);
        // R9: persistent cause re-raises after one clear cycle
        cycle(1, 3'd0, 6'h02, 6'h00, 3'd0);
        check("R9 cleared one cycle", {5'b0, irq_evt}, 6'h00);
        cycle(0, 3'd0, 6'h00, 6'h00, 3'd0);
        check("R9 re-raised", {5'b0, irq_evt}, 6'h01);
        // R8: disable drops output, pending kept
        cycle(1, 3'd1, 6'h01, 6'h00, 3'd0);
        check("R8 output gated", {5'b0, irq_evt}, 6'h00);
        check("R8 pending kept", rd_data, 6'h02);
        // R6: no raise while disabled, raise one edge after enable
        cycle(1, 3'd0, 6'h02, 6'h00, 3'd0);
        cycle(0, 3'd0, 6'h00, 6'h00, 3'd0);
        check("R6 disabled no raise", rd_data, 6'h00);
        cycle(1, 3'd1, 6'h03, 6'h00, 3'd0);
        check("R6 not raised on enable edge", rd_data, 6'h00);
        cycle(0, 3'd0, 6'h00, 6'h00, 3'd0);
        check("R6 raised after enable", {5'b0, irq_evt}, 6'h01);
        // R2: set wins over clear in the same cycle
        cycle(1, 3'd4, 6'h04, 6'h04, 3'd4);
        check("R2 set wins", rd_data & 6'h04, 6'h04);

        // random phase against the model
        for (int i = 0; i < 4000; i++) begin
            logic we;
            if (i % 8 == 0) evt_level = 6'($urandom);
            we = ($urandom % 3) == 0;
            cycle(we, 3'($urandom), 6'($urandom),
                  (($urandom % 4) == 0) ? 6'($urandom) : 6'h00, 3'(i % 8));
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule